// File: doc/BRIEF.md
# Programmable External Bus Controller

This block converts word and byte requests from an internal CPU-side bus into cycles on an external memory bus. Every request is matched against up to five address windows. Each window has its own attribute set: address and data on one shared 16-bit port or on two separate ports, an 8-bit or 16-bit data path, a wait-state count, an optional second address-latch-enable cycle, an optional idle cycle before the read or write strobe, and an optional ready handshake that lets a slow device stretch the strobe. An address that hits no enabled window uses a default attribute set.

The CPU side uses a valid/ready handshake. A request is accepted only when the controller is idle. A read returns its data with a one-cycle response pulse, and a write also ends with that pulse. The external address is 16, 18, 20 or 24 bits wide. The upper eight lines stay low unless a wider setting exposes them. A 16-bit request aimed at an 8-bit window becomes two byte cycles, low byte first.

Top module: `ext_bus_ctrl`

## Requirements
- R1: Window i (0..4) matches when its enable bit is set and (address AND mask_i) equals base_i. The lowest-numbered matching window supplies the attributes. With no match, the default attribute input applies. Disabled windows never match.
- R2: Attribute word, MSB first: bit 8 shared-port mode, bit 7 16-bit width, bits 6:3 wait states, bit 2 long ALE, bit 1 strobe delay, bit 0 ready enable. In shared-port mode the address appears on `ext_ad_out` while ALE is high. In separate-port mode it appears on `ext_a_out` for the whole cycle.
- R3: Byte enables: bit 0 is the low byte, bit 1 the high byte. Address bit 0 on the bus is 1 only for a high-byte-only request, or for the second part of a split. A 16-bit request (enables 11) to an 8-bit window runs two parts, even address first, then odd. `ext_bhe_n` equals NOT enable bit 1 on 16-bit windows and is 1 on 8-bit windows.
- R4: `addr_sel` codes 0, 1, 2 and 3 give 16, 18, 20 and 24 address bits. Address bits above the selected width are driven 0, so `ext_a_hi` is 0 for code 0.
- R5: Without ready stretching, the active strobe of each part lasts wait states + 1 cycles.
- R6: ALE is high for 1 cycle per part, or for 2 cycles when long ALE is set.
- R7: Each part has exactly one strobe-free, ALE-free cycle after the strobe (the hold cycle). It has one more such cycle between ALE and strobe when strobe delay is set.
- R8: With ready enabled, `ext_ready` is sampled at the end of each strobe cycle from the last wait-state cycle onward. The strobe ends after the first such cycle where it is high. With ready disabled, `ext_ready` has no effect.
- R9: `req_ready` is high only when idle. A request is busy for parts*(2+longALE+delay) cycles plus its total strobe cycles. `rsp_valid` is high for exactly one cycle: the hold cycle of the last part.
- R10: Read data is captured on the final strobe cycle. A 16-bit window returns the whole port word. An 8-bit window places each byte in the lane given by its bus address bit 0, and leaves lanes that were not fetched at 0.
- R11: On writes, `ext_ad_out` carries write data from the cycle after ALE through the hold cycle. On an 8-bit window, the selected byte sits in bits 7:0 and bits 15:8 are 0. The port is never driven while the read strobe is low, and only the strobe matching the request direction ever goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_sel | input | 2 | External address width code |
| cfg_win_en | input | NWIN | Window enable bits |
| cfg_win_base | input | NWIN*24 | Window base addresses, window i at bits i*24 |
| cfg_win_mask | input | NWIN*24 | Window compare masks |
| cfg_win_attr | input | NWIN*9 | Window attribute words |
| cfg_dflt_attr | input | 9 | Attributes used when no window matches |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle, request accepted |
| req_addr | input | 24 | Request byte address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Access complete |
| rsp_rdata | output | 16 | Read data |
| ext_ale | output | 1 | Address latch enable |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_bhe_n | output | 1 | High byte enable, active low |
| ext_ad_out | output | 16 | Shared address/data port, output value |
| ext_ad_oe | output | 1 | Output enable for ext_ad_out |
| ext_ad_in | input | 16 | Shared port, input value |
| ext_a_out | output | 16 | Separate address port, lines 15:0 |
| ext_a_hi | output | 8 | Address lines 23:16 |
| ext_ready | input | 1 | External ready, active high |

## Verification
Each accepted request enters ALE on the cycle after the accepting edge. Every bus result appears on the same cycle as the state that causes it: the address at the first ALE cycle, write data during strobe cycles, and `rsp_valid` with the read data on the hold cycle of the last part. The bench samples all of these at the falling edge. From the moment of acceptance, it counts busy, ALE, strobe and gap cycles. It then compares these counts with the per-part formulas in R5 to R9. The ready input is driven on the falling edge inside each strobe cycle, so the value sampled at the closing edge of strobe cycle k is known to be (k >= threshold). The expected stretch is therefore max(wait states + 1, threshold).

// File: rtl/ebc_pkg.sv
package ebc_pkg;

    localparam int ADDR_W = 24;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;
    localparam int LO_AW  = 16;
    localparam int WS_W   = 4;
    localparam int RUN_W  = 8;

    typedef struct packed {
        logic            mux;       // shared address/data port
        logic            wide;      // 16-bit data path
        logic [WS_W-1:0] ws;        // wait states
        logic            ale_long;  // second ALE cycle
        logic            rw_dly;    // idle cycle before strobe
        logic            rdy_en;    // ready handshake enabled
    } win_attr_t;

    localparam int ATTR_W = $bits(win_attr_t);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ALEX,
        ST_DLY,
        ST_STRB,
        ST_RDYW,
        ST_HOLD
    } bus_st_t;

    // Keep only the address lines exposed by the width code.
    function automatic logic [ADDR_W-1:0] width_mask(input logic [1:0] sel);
        logic [ADDR_W-1:0] m;
        case (sel)
            2'd0:    m = 24'h00FFFF;
            2'd1:    m = 24'h03FFFF;
            2'd2:    m = 24'h0FFFFF;
            default: m = 24'hFFFFFF;
        endcase
        return m;
    endfunction

    // A full word to a byte-wide window takes two bus parts.
    function automatic logic split_needed(input win_attr_t a, input logic [1:0] be);
        return !a.wide && (be == 2'b11);
    endfunction

endpackage

// File: rtl/ebc_win_decode.sv
module ebc_win_decode
    import ebc_pkg::*;
#(
    parameter int NWIN = 5
)
(
    input  logic [ADDR_W-1:0]      addr,
    input  logic [NWIN-1:0]        win_en,
    input  logic [NWIN*ADDR_W-1:0] win_base,
    input  logic [NWIN*ADDR_W-1:0] win_mask,
    input  logic [NWIN*ATTR_W-1:0] win_attr,
    input  win_attr_t              dflt_attr,
    output win_attr_t              sel_attr
);

    localparam int IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1;

    logic [NWIN-1:0]  match;
    logic             hit;
    logic [IDX_W-1:0] idx;

    generate
        for (genvar g = 0; g < NWIN; g++) begin : g_win
            assign match[g] = win_en[g] &&
                ((addr & win_mask[g*ADDR_W +: ADDR_W]) == win_base[g*ADDR_W +: ADDR_W]);
        end
    endgenerate

    // Scan downward so the lowest matching index is the one kept.
    always_comb begin
        sel_attr = dflt_attr;
        hit      = 1'b0;
        idx      = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (match[i]) begin
                sel_attr = win_attr[i*ATTR_W +: ATTR_W];
                hit      = 1'b1;
                idx      = IDX_W'(i);
            end
        end
        a_hit_consistent_r1: assert (!hit || (win_en[idx] &&
            ((addr & win_mask[idx*ADDR_W +: ADDR_W]) == win_base[idx*ADDR_W +: ADDR_W])))
            else $error("selected window does not match address");
    end

endmodule

// File: rtl/ebc_lane.sv
module ebc_lane
    import ebc_pkg::*;
(
    input  logic [ADDR_W-2:0] word_addr,
    input  logic [1:0]        be,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wide,
    input  logic              part,
    input  logic [1:0]        aw_sel,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bhe_n,
    output logic              lane_hi
);

    logic a0;

    // Odd byte for a high-only request or for the second part of a split.
    assign a0        = part | (be == 2'b10);
    assign lane_hi   = a0;
    assign bus_addr  = {word_addr, a0} & width_mask(aw_sel);
    assign bus_wdata = wide ? wdata
                     : {{(DATA_W-BYTE_W){1'b0}},
                        a0 ? wdata[DATA_W-1:BYTE_W] : wdata[BYTE_W-1:0]};
    assign bhe_n     = wide ? ~be[1] : 1'b1;

endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
    import ebc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      two_parts,
    input  logic      ready,
    input  win_attr_t attr,
    output bus_st_t   st,
    output logic      part,
    output logic      cap
);

    bus_st_t          st_q, st_d;
    logic [WS_W-1:0]  cnt_q;
    logic             part_q;
    logic [RUN_W-1:0] run_q;
    logic             last_wait;
    logic             rdy_ok;
    logic             strobe;

    assign last_wait = (cnt_q == attr.ws);
    assign rdy_ok    = !attr.rdy_en || ready;
    assign strobe    = (st_q == ST_STRB) || (st_q == ST_RDYW);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start) st_d = ST_ADDR;
            ST_ADDR: st_d = attr.ale_long ? ST_ALEX : (attr.rw_dly ? ST_DLY : ST_STRB);
            ST_ALEX: st_d = attr.rw_dly ? ST_DLY : ST_STRB;
            ST_DLY:  st_d = ST_STRB;
            ST_STRB: if (last_wait) st_d = rdy_ok ? ST_HOLD : ST_RDYW;
            ST_RDYW: if (ready) st_d = ST_HOLD;
            ST_HOLD: st_d = (two_parts && !part_q) ? ST_ADDR : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            part_q <= 1'b0;
            run_q  <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= (st_q == ST_STRB && !last_wait) ? cnt_q + 1'b1 : '0;
            if (st_q == ST_IDLE)
                part_q <= 1'b0;
            else if (st_q == ST_HOLD)
                part_q <= 1'b1;
            if (strobe)
                run_q <= (run_q == {RUN_W{1'b1}}) ? run_q : run_q + 1'b1;
            else
                run_q <= '0;
        end
    end

    assign st   = st_q;
    assign part = part_q;
    assign cap  = (st_q == ST_STRB && last_wait && rdy_ok) || (st_q == ST_RDYW && ready);

    p_wait_len_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HOLD) |-> (run_q > {{(RUN_W-WS_W){1'b0}}, attr.ws}));

    p_ale_ext_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ADDR && attr.ale_long) |=> (st_q == ST_ALEX));

    p_strobe_delay_r7: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_STRB && $past(st_q) != ST_STRB && attr.rw_dly) |-> ($past(st_q) == ST_DLY));

    p_ready_stretch_r8: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RDYW && !ready) |=> (st_q == ST_RDYW));

endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
    import ebc_pkg::*;
#(
    parameter int NWIN = 5
)
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             addr_sel,
    input  logic [NWIN-1:0]        cfg_win_en,
    input  logic [NWIN*ADDR_W-1:0] cfg_win_base,
    input  logic [NWIN*ADDR_W-1:0] cfg_win_mask,
    input  logic [NWIN*ATTR_W-1:0] cfg_win_attr,
    input  logic [ATTR_W-1:0]      cfg_dflt_attr,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    input  logic [1:0]             req_be,
    input  logic                   req_write,
    output logic                   rsp_valid,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic                   ext_ale,
    output logic                   ext_rd_n,
    output logic                   ext_wr_n,
    output logic                   ext_bhe_n,
    output logic [DATA_W-1:0]      ext_ad_out,
    output logic                   ext_ad_oe,
    input  logic [DATA_W-1:0]      ext_ad_in,
    output logic [LO_AW-1:0]       ext_a_out,
    output logic [ADDR_W-LO_AW-1:0] ext_a_hi,
    input  logic                   ext_ready
);

    win_attr_t         dec_attr;
    win_attr_t         r_attr;
    logic [ADDR_W-2:0] r_waddr;
    logic [DATA_W-1:0] r_wdata;
    logic [1:0]        r_be;
    logic              r_write;
    logic [DATA_W-1:0] rdata_q;

    bus_st_t           st;
    logic              part;
    logic              cap;
    logic              accept;
    logic              two;

    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic              bhe_n;
    logic              lane_hi;

    logic              active, ale_ph, strb_ph, data_ph;

    ebc_win_decode #(.NWIN(NWIN)) u_dec (
        .addr      (req_addr),
        .win_en    (cfg_win_en),
        .win_base  (cfg_win_base),
        .win_mask  (cfg_win_mask),
        .win_attr  (cfg_win_attr),
        .dflt_attr (win_attr_t'(cfg_dflt_attr)),
        .sel_attr  (dec_attr)
    );

    assign req_ready = (st == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign two       = split_needed(r_attr, r_be);

    ebc_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .two_parts (two),
        .ready     (ext_ready),
        .attr      (r_attr),
        .st        (st),
        .part      (part),
        .cap       (cap)
    );

    ebc_lane u_lane (
        .word_addr (r_waddr),
        .be        (r_be),
        .wdata     (r_wdata),
        .wide      (r_attr.wide),
        .part      (part),
        .aw_sel    (addr_sel),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bhe_n     (bhe_n),
        .lane_hi   (lane_hi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            r_attr  <= '0;
            r_waddr <= '0;
            r_wdata <= '0;
            r_be    <= '0;
            r_write <= 1'b0;
            rdata_q <= '0;
        end else if (accept) begin
            r_attr  <= dec_attr;
            r_waddr <= req_addr[ADDR_W-1:1];
            r_wdata <= req_wdata;
            r_be    <= req_be;
            r_write <= req_write;
            rdata_q <= '0;
        end else if (cap) begin
            if (r_attr.wide)
                rdata_q <= ext_ad_in;
            else if (lane_hi)
                rdata_q[DATA_W-1:BYTE_W] <= ext_ad_in[BYTE_W-1:0];
            else
                rdata_q[BYTE_W-1:0] <= ext_ad_in[BYTE_W-1:0];
        end
    end

    assign active  = (st != ST_IDLE);
    assign ale_ph  = (st == ST_ADDR) || (st == ST_ALEX);
    assign strb_ph = (st == ST_STRB) || (st == ST_RDYW);
    assign data_ph = (st == ST_DLY) || strb_ph || (st == ST_HOLD);

    assign ext_ale    = ale_ph;
    assign ext_rd_n   = !(strb_ph && !r_write);
    assign ext_wr_n   = !(strb_ph && r_write);
    assign ext_bhe_n  = active ? bhe_n : 1'b1;
    assign ext_ad_oe  = (r_attr.mux && ale_ph) || (r_write && data_ph);
    assign ext_ad_out = (r_attr.mux && ale_ph) ? bus_addr[LO_AW-1:0]
                      : ((r_write && data_ph) ? bus_wdata : '0);
    assign ext_a_out  = (active && !r_attr.mux) ? bus_addr[LO_AW-1:0] : '0;
    assign ext_a_hi   = active ? bus_addr[ADDR_W-1:LO_AW] : '0;

    assign rsp_valid = (st == ST_HOLD) && (part || !two);
    assign rsp_rdata = rdata_q;

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (ext_rd_n && ext_wr_n && !ext_ale));

    p_accept_ale_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> ext_ale);

    p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    p_no_read_drive_r11: assert property (@(posedge clk) disable iff (rst)
        !ext_rd_n |-> !ext_ad_oe);

    p_hi_lines_r4: assert property (@(posedge clk) disable iff (rst)
        (addr_sel == 2'd0) |-> (ext_a_hi == '0));

endmodule

// File: tb/ext_bus_ctrl_bench.sv
`timescale 1ns/1ps
module ext_bus_ctrl_bench;
    import ebc_pkg::*;

    localparam int NWIN = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [1:0]             addr_sel;
    logic [NWIN-1:0]        cfg_win_en;
    logic [NWIN*ADDR_W-1:0] cfg_win_base, cfg_win_mask;
    logic [NWIN*ATTR_W-1:0] cfg_win_attr;
    logic [ATTR_W-1:0]      cfg_dflt_attr;
    logic                   req_valid, req_ready, req_write;
    logic [ADDR_W-1:0]      req_addr;
    logic [DATA_W-1:0]      req_wdata, rsp_rdata, ext_ad_out, ext_ad_in;
    logic [1:0]             req_be;
    logic                   rsp_valid, ext_ale, ext_rd_n, ext_wr_n, ext_bhe_n, ext_ad_oe, ext_ready;
    logic [15:0]            ext_a_out;
    logic [7:0]             ext_a_hi;

    ext_bus_ctrl #(.NWIN(NWIN)) u_ext_bus_ctrl (
        .clk(clk), .rst(rst), .addr_sel(addr_sel),
        .cfg_win_en(cfg_win_en), .cfg_win_base(cfg_win_base), .cfg_win_mask(cfg_win_mask),
        .cfg_win_attr(cfg_win_attr), .cfg_dflt_attr(cfg_dflt_attr),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ext_ale(ext_ale), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n), .ext_bhe_n(ext_bhe_n),
        .ext_ad_out(ext_ad_out), .ext_ad_oe(ext_ad_oe), .ext_ad_in(ext_ad_in),
        .ext_a_out(ext_a_out), .ext_a_hi(ext_a_hi), .ext_ready(ext_ready)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    int rdy_after = 0;

    int          obs_busy, obs_ale, obs_strb, obs_gap, obs_parts, obs_oebad, obs_wrong;
    logic [23:0] obs_pa [2];
    logic [15:0] obs_pw [2];
    logic        obs_pb [2];
    logic [15:0] obs_rd;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mem_model(input logic [23:0] a);
        return {a[7:0] ^ 8'hA5, a[15:8] ^ a[23:16] ^ 8'h3C};
    endfunction

    function automatic logic [23:0] wmask(input logic [1:0] s);
        int bits;
        bits = (s == 2'd3) ? 24 : 16 + 2 * int'(s);
        return 24'((64'd1 << bits) - 1);
    endfunction

    function automatic logic [8:0] mk_attr(input bit mx, input bit wd, input int ws,
                                           input bit al, input bit dl, input bit re);
        win_attr_t t;
        t.mux = mx; t.wide = wd; t.ws = 4'(ws);
        t.ale_long = al; t.rw_dly = dl; t.rdy_en = re;
        return t;
    endfunction

    task automatic run_txn(input logic [23:0] a, input logic [15:0] wd,
                           input logic [1:0] be, input logic wr, input bit mx);
        int  sc;
        bit  prev_ale, done, strobe;
        logic [23:0] pa;
        obs_busy = 0; obs_ale = 0; obs_strb = 0; obs_gap = 0;
        obs_parts = 0; obs_oebad = 0; obs_wrong = 0; obs_rd = '0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_wdata = wd; req_be = be; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        sc = 0; prev_ale = 1'b0; done = 1'b0;
        while (!done && obs_busy < 400) begin
            obs_busy++;
            if (ext_ale) begin
                obs_ale++;
                if (!prev_ale) begin
                    pa = mx ? {ext_a_hi, ext_ad_out} : {ext_a_hi, ext_a_out};
                    if (obs_parts < 2) begin
                        obs_pa[obs_parts] = pa;
                        obs_pb[obs_parts] = ext_bhe_n;
                    end
                    ext_ad_in = mem_model(pa);
                    obs_parts++;
                end
            end
            strobe = wr ? !ext_wr_n : !ext_rd_n;
            if (wr ? !ext_rd_n : !ext_wr_n) obs_wrong++;
            if (strobe) begin
                obs_strb++;
                sc++;
                if (obs_parts >= 1 && obs_parts <= 2) obs_pw[obs_parts-1] = ext_ad_out;
                if (ext_ad_oe != wr) obs_oebad++;
            end else begin
                sc = 0;
                if (!ext_ale) obs_gap++;
            end
            ext_ready = (sc >= rdy_after);
            if (rsp_valid) begin
                done = 1'b1;
                obs_rd = rsp_rdata;
            end
            prev_ale = ext_ale;
            @(negedge clk);
        end
    endtask

    // One sweep transaction with all expected values computed from the requirements.
    task automatic sweep_one(input bit mx, input bit wd, input int ws, input bit al,
                             input bit dl, input bit re, input bit wr,
                             input logic [1:0] be, input logic [23:0] a, input logic [15:0] wdat);
        int parts, per_strb, e_busy;
        logic [23:0] ea [2];
        logic [15:0] ew, erd;
        bit a0;
        parts    = (!wd && be == 2'b11) ? 2 : 1;
        per_strb = (re && rdy_after > ws + 1) ? rdy_after : ws + 1;
        e_busy   = parts * (2 + int'(al) + int'(dl)) + parts * per_strb;
        run_txn(a, wdat, be, wr, mx);
        chk(obs_busy == e_busy, "R9", "busy cycles", obs_busy, e_busy);
        chk(obs_ale == parts * (1 + int'(al)), "R6", "ALE cycles", obs_ale, parts * (1 + int'(al)));
        chk(obs_strb == parts * per_strb, re ? "R8" : "R5", "strobe cycles", obs_strb, parts * per_strb);
        chk(obs_gap == parts * (1 + int'(dl)), "R7", "gap cycles", obs_gap, parts * (1 + int'(dl)));
        chk(obs_parts == parts, "R3", "part count", obs_parts, parts);
        chk(obs_wrong == 0 && obs_oebad == 0, "R11", "strobe/drive errors", obs_wrong + obs_oebad, 0);
        erd = '0;
        for (int p = 0; p < parts && p < obs_parts; p++) begin
            a0 = (p == 1) || (be == 2'b10);
            ea[p] = {a[23:1], a0} & wmask(addr_sel);
            chk(obs_pa[p] == ea[p], "R2", "bus address", obs_pa[p], ea[p]);
            chk(obs_pb[p] == (wd ? ~be[1] : 1'b1), "R3", "bhe_n", obs_pb[p], wd ? ~be[1] : 1'b1);
            if (wd) begin
                ew  = wdat;
                erd = mem_model(ea[p]);
            end else begin
                ew = {8'h00, a0 ? wdat[15:8] : wdat[7:0]};
                if (a0) erd[15:8] = mem_model(ea[p]) & 16'h00FF;
                else    erd[7:0]  = mem_model(ea[p]) & 16'h00FF;
            end
            if (wr) chk(obs_pw[p] == ew, "R11", "write data", obs_pw[p], ew);
        end
        if (!wr) chk(obs_rd == erd, "R10", "read data", obs_rd, erd);
    endtask

    task automatic dec_probe(input logic [23:0] a, input int exp_ws, input string what);
        rdy_after = 0;
        run_txn(a, 16'h0, 2'b11, 1'b0, 1'b0);
        chk(obs_busy == 3 + exp_ws, "R1", what, obs_busy, 3 + exp_ws);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int k;
        addr_sel = 2'd3; cfg_win_en = '0; cfg_win_base = '0; cfg_win_mask = '0;
        cfg_win_attr = '0; cfg_dflt_attr = mk_attr(0, 1, 0, 0, 0, 0);
        req_valid = 0; req_addr = '0; req_wdata = '0; req_be = 2'b11; req_write = 0;
        ext_ad_in = '0; ext_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R9", "reset req_ready", req_ready, 1);
        chk({ext_ale, ext_rd_n, ext_wr_n, ext_ad_oe, rsp_valid} == 5'b01100, "R9",
            "reset pins", {ext_ale, ext_rd_n, ext_wr_n, ext_ad_oe, rsp_valid}, 5'b01100);

        // Sweep of every attribute combination on window 0.
        cfg_win_en = 5'b00001;
        cfg_win_base[0 +: 24] = 24'h040000;
        cfg_win_mask[0 +: 24] = 24'hFC0000;
        k = 0;
        for (int mx = 0; mx < 2; mx++)
        for (int wd = 0; wd < 2; wd++)
        for (int wi = 0; wi < 3; wi++)
        for (int al = 0; al < 2; al++)
        for (int dl = 0; dl < 2; dl++)
        for (int re = 0; re < 2; re++)
        for (int ti = 0; ti < 2; ti++)
        for (int wr = 0; wr < 2; wr++)
        for (int bi = 1; bi < 4; bi++) begin
            int ws;
            ws = (wi == 2) ? 3 : wi;
            cfg_win_attr[0 +: 9] = mk_attr(mx[0], wd[0], ws, al[0], dl[0], re[0]);
            rdy_after = ti ? 6 : 0;
            addr_sel  = 2'(k % 4);
            sweep_one(mx[0], wd[0], ws, al[0], dl[0], re[0], wr[0], 2'(bi),
                      24'h040000 | ((24'(k) * 24'h0A5B3) & 24'h03FFFF),
                      16'(k * 16'h3B71 + 16'h1234));
            k++;
        end

        // Window priority, disabled windows and the default set.
        addr_sel = 2'd3;
        cfg_dflt_attr = mk_attr(0, 1, 9, 0, 0, 0);
        cfg_win_base[0*24 +: 24] = 24'h010000; cfg_win_mask[0*24 +: 24] = 24'hFF0000;
        cfg_win_attr[0*9 +: 9] = mk_attr(0, 1, 2, 0, 0, 0);
        cfg_win_base[1*24 +: 24] = 24'h010000; cfg_win_mask[1*24 +: 24] = 24'hFFF000;
        cfg_win_attr[1*9 +: 9] = mk_attr(0, 1, 5, 0, 0, 0);
        cfg_win_base[2*24 +: 24] = 24'h200000; cfg_win_mask[2*24 +: 24] = 24'hF00000;
        cfg_win_attr[2*9 +: 9] = mk_attr(0, 1, 1, 0, 0, 0);
        cfg_win_base[3*24 +: 24] = 24'h200000; cfg_win_mask[3*24 +: 24] = 24'hF00000;
        cfg_win_attr[3*9 +: 9] = mk_attr(0, 1, 4, 0, 0, 0);
        cfg_win_base[4*24 +: 24] = 24'h300000; cfg_win_mask[4*24 +: 24] = 24'hF00000;
        cfg_win_attr[4*9 +: 9] = mk_attr(0, 1, 7, 0, 0, 0);
        cfg_win_en = 5'b10011;
        dec_probe(24'h010122, 2, "lowest index wins");
        cfg_win_en = 5'b10010;
        dec_probe(24'h010122, 5, "next window after disable");
        dec_probe(24'h011122, 9, "no match uses default");
        dec_probe(24'h200010, 9, "disabled windows ignored");
        dec_probe(24'h3ABCDE, 7, "highest window");
        cfg_win_en = 5'b11110;
        dec_probe(24'h200010, 1, "window 2 over window 3");

        // Address width codes on one fixed address.
        for (int s = 0; s < 4; s++) begin
            logic [7:0] eh;
            addr_sel = 2'(s);
            eh = 8'((24'hABCDEE & wmask(2'(s))) >> 16);
            run_txn(24'h3BCDEE, 16'h0, 2'b11, 1'b0, 1'b0);
            chk(obs_pa[0][23:16] == (eh & 8'h3F) | 8'(s == 3 ? 8'h00 : 8'h00) || s == 3 ? obs_pa[0][23:16] == 8'((24'h3BCDEE & wmask(2'(s))) >> 16) : 1'b0,
                "R4", "upper address lines", obs_pa[0][23:16], 8'((24'h3BCDEE & wmask(2'(s))) >> 16));
            chk(obs_pa[0][23:16] == 8'((24'h3BCDEE & wmask(2'(s))) >> 16), "R4",
                "masked upper lines", obs_pa[0][23:16], 8'((24'h3BCDEE & wmask(2'(s))) >> 16));
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule